// File: doc/BRIEF.md
# Dual-Slope PWM Compare Timer

A W-bit up/down timer with NCH compare channels (channel 0 is channel A). A single-cycle timer-clock enable (`tick`) advances it. A two-bit mode input selects one of four counting schemes:

| `mode` | Counting scheme |
|--------|-----------------|
| 0 | Free-running count that wraps at the maximum value |
| 1 | Clear-on-compare: the counter returns to zero after it reaches channel A's compare value |
| 2 | Dual-slope PWM, TOP taken from a separate TOP register |
| 3 | Dual-slope PWM, TOP taken from channel A's compare register |

Every channel has a two-bit output mode. It drives one waveform bit, and it raises a match flag whenever the counter equals that channel's compare value.

In the dual-slope modes, compare values are double-buffered. They are copied from their buffers once per period, at the bottom of the count. Because of this, both slopes of every period are equally long. In the other two modes a compare write takes effect at once.

Software can load the counter directly. It can also force a compare action without a match. Flags drive interrupt requests through per-source enables. A flag is cleared by acknowledging it on the clear inputs. The prescaler, the pin multiplexing and the byte-wide register access path sit outside this block.

Top module: `dslope_timer`

## Requirements
- R1: In mode 0 the counter adds one per tick and wraps from all-ones to 0. The overflow flag is set by the tick that performs the wrap. Without a tick and without a counter write, the counter holds.
- R2: In mode 1, on a tick where the counter equals channel A's compare register, the counter goes to 0 instead of incrementing.
- R3: In mode 2 and mode 3, the counter steps by one per tick: from 0 up to TOP, then back down to 0. It shows TOP and 0 for exactly one tick each. TOP comes from the TOP register in mode 2 and from channel A's compare register in mode 3. The smallest legal TOP is 3.
- R4: In modes 2 and 3, a compare write lands only in that channel's buffer. The buffer is copied into the compare register on the tick at which the counter is 0, and the overflow flag is set on that same tick. In modes 0 and 1 a compare write updates the register immediately.
- R5: A channel's match flag is set at the end of a tick on which the counter equals its compare register.
- R6: In the dual-slope modes, a match with output mode 2 drives the wave low if the count is heading up and high if it is heading down. Output mode 3 does the opposite. At TOP the count is considered to be heading down, and at 0 it is considered to be heading up.
- R7: In the dual-slope modes with output mode 2, the wave behaves as follows:
  - a compare value of 0 gives a wave that stays low;
  - a compare value equal to TOP gives a wave that stays high;
  - a compare value above TOP never sets the flag.
- R8: Output mode 1 toggles the wave on each match. In mode 3, channel A therefore toggles once per period, giving 50% duty.
- R9: In modes 0 and 1, a match or a force acts on the wave as follows:
  - output mode 1 toggles it;
  - output mode 2 clears it;
  - output mode 3 sets it;
  - output mode 0 leaves it unchanged.
- R10: A force strobe works only in modes 0 and 1. It applies the channel's action without a tick, sets no flag and does not move the counter. In the dual-slope modes it is ignored. A force that coincides with a match applies the action once.
- R11: A counter write loads the value and takes priority over a tick in the same cycle. Matches are suppressed on that cycle's tick and on the next tick, for all channels.
- R12: The flag and interrupt vectors use bit i for channel i and bit NCH for overflow. A one on `flag_clr` clears the corresponding flag, but a set in the same cycle wins. `irq` is the flag ANDed with its enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-clock enable |
| mode | input | 2 | Counting mode, 0 to 3 |
| com | input | 2*NCH | Output mode of each channel; bits 2i+1:2i belong to channel i |
| cmp_wr | input | NCH | Compare write strobe per channel |
| cmp_wdata | input | W | Compare write data |
| cap_wr | input | 1 | TOP register write strobe |
| cap_wdata | input | W | TOP register write data |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | W | Counter write data |
| force_cmp | input | NCH | Force-compare strobes |
| flag_clr | input | NCH+1 | Flag clear/acknowledge |
| irq_en | input | NCH+1 | Interrupt enables |
| cnt | output | W | Counter value |
| wave | output | NCH | Waveform outputs |
| cmp_flag | output | NCH | Match flags |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | NCH+1 | Interrupt requests |

## Verification
Three pairs of functions can fall in the same cycle.

- **Flag set against flag clear.** The overflow flag's acknowledge is driven on the very tick that wraps the counter. The flag is expected to end up set.
- **Force strobe against a real match.** A force is issued on the tick where the counter equals channel A's value, with output mode 1. The wave is expected to toggle once, not twice, and the flag is expected to be set.
- **Counter write against a tick.** A counter write is issued in the same cycle as a tick. The written value is expected to win, and the next tick's match is expected to be dropped.

// File: rtl/dslope_timer.sv
module dslope_timer #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       mode,
  input  logic [2*NCH-1:0] com,
  input  logic [NCH-1:0]   cmp_wr,
  input  logic [W-1:0]     cmp_wdata,
  input  logic             cap_wr,
  input  logic [W-1:0]     cap_wdata,
  input  logic             cnt_wr,
  input  logic [W-1:0]     cnt_wdata,
  input  logic [NCH-1:0]   force_cmp,
  input  logic [NCH:0]     flag_clr,
  input  logic [NCH:0]     irq_en,
  output logic [W-1:0]     cnt,
  output logic [NCH-1:0]   wave,
  output logic [NCH-1:0]   cmp_flag,
  output logic             ovf_flag,
  output logic [NCH:0]     irq
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [1:0] M_FREE = 2'd0, M_CTC = 2'd1, M_DSCAP = 2'd2;

  logic [W-1:0] cnt_q, cap_q, top, cnt_nx;
  logic [W-1:0] creg [NCH];
  logic dir_q, blk_q, dual, next_up, adv, bottom, ovf_q;

  assign dual    = mode[1];
  assign top     = (mode == M_DSCAP) ? cap_q : creg[0];
  assign adv     = tick && !cnt_wr;
  assign bottom  = adv && dual && (cnt_q == '0);
  assign next_up = (cnt_q >= top) ? 1'b0 : (cnt_q == '0) ? 1'b1 : dir_q;

  always_comb begin
    case (mode)
      M_FREE:  cnt_nx = cnt_q + 1'b1;
      M_CTC:   cnt_nx = (cnt_q == top) ? '0 : cnt_q + 1'b1;
      default: cnt_nx = next_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
      dir_q <= 1'b1;
      blk_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (cap_wr) cap_q <= cap_wdata;
      if (cnt_wr)   cnt_q <= cnt_wdata;
      else if (tick) cnt_q <= cnt_nx;
      if (!dual)    dir_q <= 1'b1;
      else if (adv) dir_q <= next_up;
      if (cnt_wr)    blk_q <= 1'b1;
      else if (tick) blk_q <= 1'b0;
      if (adv && (dual ? (cnt_q == '0) : (cnt_q == MAXV))) ovf_q <= 1'b1;
      else if (flag_clr[NCH])                              ovf_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [W-1:0] buf_q, reg_q;
    logic w_q, f_q, hit, act;
    logic [1:0] cm;

    assign cm  = com[2*i +: 2];
    assign hit = adv && !blk_q && (cnt_q == reg_q);
    assign act = hit || (force_cmp[i] && !dual);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        buf_q <= '0;
        reg_q <= '0;
        w_q   <= 1'b0;
        f_q   <= 1'b0;
      end else begin
        if (cmp_wr[i]) buf_q <= cmp_wdata;
        if (cmp_wr[i] && !dual) reg_q <= cmp_wdata;
        else if (bottom)        reg_q <= buf_q;
        if (act) begin
          case (cm)
            2'd1:    w_q <= ~w_q;
            2'd2:    w_q <= dual ? ~next_up : 1'b0;
            2'd3:    w_q <= dual ? next_up : 1'b1;
            default: w_q <= w_q;
          endcase
        end
        if (hit)              f_q <= 1'b1;
        else if (flag_clr[i]) f_q <= 1'b0;
      end
    end

    assign creg[i]     = reg_q;
    assign wave[i]     = w_q;
    assign cmp_flag[i] = f_q;
  end

  assign cnt      = cnt_q;
  assign ovf_flag = ovf_q;
  assign irq      = {ovf_q, cmp_flag} & irq_en;
endmodule

// File: rtl/dslope_timer_chk.sv
module dslope_timer_chk #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           cnt_wr,
  input logic           dual,
  input logic           blk_q,
  input logic [W-1:0]   top,
  input logic [W-1:0]   cnt,
  input logic [NCH-1:0] force_cmp,
  input logic [NCH:0]   flag_clr,
  input logic [NCH-1:0] wave,
  input logic [NCH-1:0] cmp_flag,
  input logic           ovf_flag
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && dual && top >= W'(3) && cnt <= top) |=>
      ((cnt - $past(cnt)) == W'(1) || ($past(cnt) - cnt) == W'(1)));

  p_flag_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((cmp_flag & ~$past(cmp_flag)) == '0));

  p_force_wave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && force_cmp == '0) |=> $stable(wave));

  p_pwm_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && !tick) |=> $stable(wave));

  p_suppress_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && tick) |=> ((cmp_flag & ~$past(cmp_flag)) == '0));

  p_ovf_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[NCH] && !tick) |=> !ovf_flag);
endmodule

bind dslope_timer dslope_timer_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .dual(dual),
  .blk_q(blk_q), .top(top), .cnt(cnt), .force_cmp(force_cmp),
  .flag_clr(flag_clr), .wave(wave), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
);

// File: tb/dslope_timer_bench.sv
module dslope_timer_bench;
  localparam int W = 16, NCH = 3;
  logic clk = 0, rst_n = 0, tick = 0, cap_wr = 0, cnt_wr = 0;
  logic [1:0] mode = 0;
  logic [2*NCH-1:0] com = '0;
  logic [NCH-1:0] cmp_wr = '0, force_cmp = '0;
  logic [W-1:0] cmp_wdata = '0, cap_wdata = '0, cnt_wdata = '0;
  logic [NCH:0] flag_clr = '0, irq_en = '0;
  logic [W-1:0] cnt;
  logic [NCH-1:0] wave, cmp_flag;
  logic ovf_flag;
  logic [NCH:0] irq;
  int checks = 0, fails = 0;
  bit done = 0;

  dslope_timer #(.W(W), .NCH(NCH)) u_dslope_timer (.*);

  always #4 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tk(int n);
    tick = 1; cyc(n); tick = 0;
  endtask

  task automatic wr_cnt(logic [W-1:0] v);
    cnt_wr = 1; cnt_wdata = v; cyc(1); cnt_wr = 0;
  endtask

  task automatic wr_cmp(int ch, logic [W-1:0] v);
    cmp_wr = '0; cmp_wr[ch] = 1'b1; cmp_wdata = v; cyc(1); cmp_wr = '0;
  endtask

  task automatic clr_all();
    flag_clr = '1; cyc(1); flag_clr = '0;
  endtask

  task automatic set_com(int ch, logic [1:0] v);
    com[2*ch +: 2] = v;
  endtask

  task automatic t_reset();
    check("R1 reset cnt", cnt, 0);
    check("R12 reset flags", {ovf_flag, cmp_flag, irq}, 0);
    check("R9 reset wave", wave, 0);
  endtask

  task automatic t_free();
    mode = 0; irq_en = '1;
    wr_cnt(16'hFFFE);
    tk(1);
    check("R1 count", cnt, 16'hFFFF);
    check("R1 no ovf yet", ovf_flag, 0);
    tk(1);
    check("R1 wrap", cnt, 0);
    check("R1 ovf set", ovf_flag, 1);
    check("R12 irq ovf", irq[NCH], 1);
    cyc(3);
    check("R1 hold", cnt, 0);
    irq_en[NCH] = 0; cyc(1);
    check("R12 irq masked", irq[NCH], 0);
    irq_en = '1;
    flag_clr[NCH] = 1; cyc(1); flag_clr = '0;
    check("R12 ovf cleared", ovf_flag, 0);
  endtask

  task automatic t_ctc();
    mode = 1; set_com(0, 2'd1);
    wr_cmp(0, 5);
    wr_cnt(0);
    tk(5);
    check("R2 at top", cnt, 5);
    check("R5 flag not yet", cmp_flag[0], 0);
    tk(1);
    check("R2 clear on compare", cnt, 0);
    check("R5 flag set", cmp_flag[0], 1);
    check("R8 toggle on match", wave[0], 1);
  endtask

  task automatic t_force();
    clr_all();
    set_com(1, 2'd3); force_cmp = 3'b010; cyc(1); force_cmp = '0;
    check("R10 force sets B", wave[1], 1);
    check("R10 force no flag", cmp_flag, 0);
    check("R10 force cnt kept", cnt, 0);
    set_com(2, 2'd3); force_cmp = 3'b100; cyc(1);
    set_com(2, 2'd2); cyc(1); force_cmp = '0;
    check("R9 set then clear C", wave[2], 0);
    force_cmp = 3'b001; cyc(1); force_cmp = '0;
    check("R9 force toggles A", wave[0], 0);
    mode = 3; force_cmp = 3'b011; cyc(1); force_cmp = '0;
    check("R10 force ignored in PWM", wave[1:0], 2'b10);
    mode = 1;
    set_com(1, 2'd2); wr_cmp(1, 2);
    tk(2);
    check("R9 before match", wave[1], 1);
    tk(1);
    check("R9 match clears", wave[1], 0);
    check("R5 flag B", cmp_flag[1], 1);
  endtask

  task automatic t_suppress();
    mode = 0; set_com(2, 2'd1);
    wr_cmp(2, 10); clr_all();
    wr_cnt(8); tk(3);
    check("R5 match flag C", cmp_flag[2], 1);
    check("R9 toggle C", wave[2], 1);
    clr_all();
    wr_cnt(10); tk(1);
    check("R11 counter", cnt, 11);
    check("R11 match suppressed flag", cmp_flag[2], 0);
    check("R11 match suppressed wave", wave[2], 1);
    tick = 1; wr_cnt(20); tick = 0;
    check("R11 write beats tick", cnt, 20);
  endtask

  task automatic t_collide();
    logic a;
    mode = 0; wr_cnt(16'hFFFF);
    tick = 1; flag_clr[NCH] = 1; cyc(1); tick = 0; flag_clr = '0;
    check("R12 set wins over clear", ovf_flag, 1);
    clr_all();
    mode = 1; set_com(0, 2'd1);
    wr_cmp(0, 6); wr_cnt(5); tk(1);
    a = wave[0];
    check("R11 blocked tick flag", cmp_flag[0], 0);
    tick = 1; force_cmp = 3'b001; cyc(1); tick = 0; force_cmp = '0;
    check("R10 single toggle", wave[0], !a);
    check("R10 match flag", cmp_flag[0], 1);
    check("R2 cleared", cnt, 0);
  endtask

  task automatic t_dual_cap();
    int exp_seq [9] = '{1, 2, 3, 4, 3, 2, 1, 0, 1};
    mode = 2;
    cap_wr = 1; cap_wdata = 4; cyc(1); cap_wr = 0;
    wr_cnt(0); clr_all();
    tk(1);
    check("R3 first step", cnt, exp_seq[0]);
    check("R4 ovf at bottom", ovf_flag, 1);
    clr_all();
    for (int k = 1; k < 9; k++) begin
      tk(1);
      check($sformatf("R3 seq %0d", k), cnt, exp_seq[k]);
      if (k == 7) check("R4 no ovf before bottom tick", ovf_flag, 0);
    end
    check("R4 ovf again", ovf_flag, 1);
    check("R7 above top no flag", cmp_flag[2], 0);
  endtask

  task automatic t_dual_buf();
    logic a0;
    mode = 3; set_com(0, 2'd1); set_com(1, 2'd2); set_com(2, 2'd0);
    wr_cnt(0);
    tk(5);
    check("R3 top from A count", cnt, 5);
    check("R6 up match clears", wave[1], 0);
    clr_all();
    wr_cmp(1, 4);
    tk(1);
    check("R3 at top", cnt, 6);
    a0 = wave[0];
    tk(1);
    check("R3 leaves top", cnt, 5);
    check("R8 A toggles at top", wave[0], !a0);
    tk(2);
    check("R4 buffered value unused", cmp_flag[1], 0);
    tk(1);
    check("R4 still no flag", cmp_flag[1], 0);
    tk(1);
    check("R6 down match sets", wave[1], 1);
    check("R5 flag on old value", cmp_flag[1], 1);
    tk(5);
    check("R4 before new match", wave[1], 1);
    tk(1);
    check("R4 new value after bottom", wave[1], 0);
    tk(2);
    check("R8 50 percent period", wave[0], a0);
  endtask

  task automatic t_extremes();
    bit okb = 1, okc = 1;
    set_com(1, 2'd2); set_com(2, 2'd2);
    wr_cmp(1, 0); wr_cmp(2, 6);
    tk(30);
    for (int k = 0; k < 12; k++) begin
      tk(1);
      if (wave[1] !== 1'b0) okb = 0;
      if (wave[2] !== 1'b1) okc = 0;
    end
    check("R7 bottom value low", okb, 1);
    check("R7 top value high", okc, 1);
    wr_cmp(2, 9);
    tk(14); clr_all(); tk(12);
    check("R7 above top never matches", cmp_flag[2], 0);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset();
    t_free();
    t_ctc();
    t_force();
    t_suppress();
    t_collide();
    t_dual_cap();
    t_dual_buf();
    t_extremes();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule